// File: doc/BRIEF.md
# Downstream Port Gating for a Four-Port Hub Repeater

This block decides, one packet at a time, which downstream ports of a hub repeater carry traffic arriving from the upstream port, and which of them switch their drivers to the slow edge mode. It takes per-port enable and speed flags, plus strobes already decoded from the upstream line: start of packet, end of the preamble PID, end of EOP, and SOF token. A full-speed packet is steered to every enabled full-speed port. Low-speed ports stay silent until a preamble PID has passed. After a short, counted wait the low-speed data that follows goes to every enabled port, and the slow drivers of the low-speed ports are on for that part of the packet.

When no downstream-bound packet is in progress, activity on an enabled downstream port turns the block around: the upstream driver is enabled in full-speed mode and every downstream driver is held off. A frame timer runs on the 12 MHz bit enable. It restarts on every SOF, wraps once per nominal frame, and raises an end-of-frame marker near the top of its count.

Top module: `hub_fwd_gate`

## Requirements
- R1: While `rst_n` is low and after its release, `drv_en`, `ls_drv_en`, `up_drv_en`, `frame_cnt` and `eof_mark` are all zero until a stimulus arrives.
- R2: A `pkt_start` strobe while idle sets `drv_en` to `port_en & ~port_ls` and keeps `ls_drv_en` at zero from the next cycle on. A `port_ls` bit of 1 marks a low-speed port.
- R3: A port whose `port_en` bit is 0 never has `drv_en` or `ls_drv_en` set. Changes to `port_en` and `port_ls` take effect on the outputs in the same cycle.
- R4: After `pre_done` (end of the preamble PID), low-speed ports stay undriven until the wait ends. From then on `drv_en` equals `port_en` and `ls_drv_en` equals `port_en & port_ls`, so full-speed ports also receive the low-speed data.
- R5: The wait after `pre_done` ends on the `LS_DELAY`-th cycle in which `bit_en` is high (default 4, that is, within four full-speed bit times). Cycles with `bit_en` low are not counted.
- R6: A `pkt_end` strobe during a downstream packet clears `drv_en` and `ls_drv_en` from the next cycle on.
- R7: While idle, with no `pkt_start`, any set bit of `dn_rx & port_en` raises `up_drv_en` from the next cycle on, and all downstream drivers stay off. When that term becomes zero, `up_drv_en` drops the cycle after. `pkt_start` takes priority over upstream activity.
- R8: `sof_seen` forces `frame_cnt` to 0 on the next cycle, whatever the state of `bit_en`.
- R9: `frame_cnt` advances by one on each cycle with `bit_en` high, and wraps from `FRAME_LEN-1` (default 11999) to 0.
- R10: `eof_mark` is high exactly when `frame_cnt` is at least `FRAME_LEN-EOF_MARGIN` (default 11968).
- R11: `pre_done` outside a full-speed downstream packet, and `pkt_start` during a packet, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | 12 MHz full-speed bit-time enable |
| port_en | input | NUM_PORTS | Per-port enabled flag |
| port_ls | input | NUM_PORTS | Per-port low-speed flag (1 = low speed) |
| dn_rx | input | NUM_PORTS | Per-port activity on the downstream line |
| pkt_start | input | 1 | Upstream start-of-packet strobe |
| pre_done | input | 1 | Strobe on the last bit of a preamble PID |
| pkt_end | input | 1 | Strobe at the end of the EOP |
| sof_seen | input | 1 | SOF token received strobe |
| drv_en | output | NUM_PORTS | Per-port downstream drive enable |
| ls_drv_en | output | NUM_PORTS | Per-port slow-edge driver enable |
| up_drv_en | output | 1 | Upstream drive enable, full-speed mode |
| frame_cnt | output | $clog2(FRAME_LEN) | Frame timer count |
| eof_mark | output | 1 | End-of-frame marker |

## Verification
The hardest point to reach from the ports is the edge of the preamble wait. The block must not turn on slow drivers after only `LS_DELAY-1` bit enables, and must turn them on at exactly the next one. The stimulus walks through this wait for every combination of the enable and speed flags. It pulses `bit_en` singly with idle cycles in between, so the output is checked after each counted tick. The frame-timer limits near 11968 and 11999 are reached by holding `bit_en` high for a full frame after an SOF.

// File: rtl/hub_gate_pkg.sv
package hub_gate_pkg;
  // Packet phases of the gate sequencer
  typedef enum logic [2:0] {
    GS_IDLE = 3'd0,  // nothing forwarded
    GS_FS   = 3'd1,  // full-speed packet downstream
    GS_PRE  = 3'd2,  // preamble seen, counting the driver turn-on wait
    GS_LS   = 3'd3,  // low-speed data downstream
    GS_UP   = 3'd4   // downstream activity repeated upstream
  } gate_state_t;
endpackage

// File: rtl/hub_gate_seq.sv
module hub_gate_seq
  import hub_gate_pkg::*;
#(
  parameter int LS_DELAY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        pkt_start,
  input  logic        pre_done,
  input  logic        pkt_end,
  input  logic        up_req,
  output gate_state_t state_o
);
  localparam int CW = $clog2(LS_DELAY + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(LS_DELAY - 1);

  gate_state_t    state_q, state_d;
  logic [CW-1:0]  win_q, win_d;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    case (state_q)
      GS_IDLE: begin
        if (pkt_start)   state_d = GS_FS;
        else if (up_req) state_d = GS_UP;
      end
      GS_FS: begin
        if (pkt_end) state_d = GS_IDLE;
        else if (pre_done) begin
          state_d = GS_PRE;
          win_d   = '0;
        end
      end
      GS_PRE: begin
        if (pkt_end) state_d = GS_IDLE;
        else if (bit_en) begin
          if (win_q == WIN_LAST) state_d = GS_LS;
          else                   win_d   = win_q + 1'b1;
        end
      end
      GS_LS: begin
        if (pkt_end) state_d = GS_IDLE;
      end
      GS_UP: begin
        if (!up_req) state_d = GS_IDLE;
      end
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

  assign state_o = state_q;

  AST_LS_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_LS) |-> ($past(state_q) == GS_PRE || $past(state_q) == GS_LS)); // R4
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_PRE) |-> (win_q <= WIN_LAST)); // R5
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && state_q != GS_IDLE && state_q != GS_UP) |=> (state_q == GS_IDLE)); // R6
endmodule

// File: rtl/hub_port_mask.sv
module hub_port_mask #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 fs_phase,
  input  logic                 ls_phase,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_ls,
  output logic [NUM_PORTS-1:0] drv_en,
  output logic [NUM_PORTS-1:0] ls_drv_en
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      drv_en[p]    = port_en[p] & ((fs_phase & ~port_ls[p]) | ls_phase);
      ls_drv_en[p] = port_en[p] & port_ls[p] & ls_phase;
    end
  end
endmodule

// File: rtl/hub_frame_timer.sv
module hub_frame_timer #(
  parameter int FRAME_LEN  = 12000,
  parameter int EOF_MARGIN = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_en,
  input  logic                         sof_seen,
  output logic [$clog2(FRAME_LEN)-1:0] frame_cnt,
  output logic                         eof_mark
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] EOF_START = CW'(FRAME_LEN - EOF_MARGIN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sof_seen)                   cnt_d = '0;
    else if (bit_en) begin
      if (cnt_q == CNT_LAST)        cnt_d = '0;
      else                          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign frame_cnt = cnt_q;
  assign eof_mark  = (cnt_q >= EOF_START);

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |=> (frame_cnt == '0)); // R8
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= CNT_LAST); // R9
  AST_EOF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eof_mark) |-> (frame_cnt == '0)); // R10
endmodule

// File: rtl/hub_fwd_gate.sv
module hub_fwd_gate
  import hub_gate_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int LS_DELAY   = 4,
  parameter int FRAME_LEN  = 12000,
  parameter int EOF_MARGIN = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_en,
  input  logic [NUM_PORTS-1:0]         port_en,
  input  logic [NUM_PORTS-1:0]         port_ls,
  input  logic [NUM_PORTS-1:0]         dn_rx,
  input  logic                         pkt_start,
  input  logic                         pre_done,
  input  logic                         pkt_end,
  input  logic                         sof_seen,
  output logic [NUM_PORTS-1:0]         drv_en,
  output logic [NUM_PORTS-1:0]         ls_drv_en,
  output logic                         up_drv_en,
  output logic [$clog2(FRAME_LEN)-1:0] frame_cnt,
  output logic                         eof_mark
);
  gate_state_t state;
  logic        up_req;
  logic        fs_phase, ls_phase;

  assign up_req   = |(dn_rx & port_en);
  assign fs_phase = (state == GS_FS) || (state == GS_PRE);
  assign ls_phase = (state == GS_LS);
  assign up_drv_en = (state == GS_UP);

  hub_gate_seq #(.LS_DELAY(LS_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .pkt_start(pkt_start), .pre_done(pre_done), .pkt_end(pkt_end),
    .up_req(up_req), .state_o(state)
  );

  hub_port_mask #(.NUM_PORTS(NUM_PORTS)) u_mask (
    .fs_phase(fs_phase), .ls_phase(ls_phase),
    .port_en(port_en), .port_ls(port_ls),
    .drv_en(drv_en), .ls_drv_en(ls_drv_en)
  );

  hub_frame_timer #(.FRAME_LEN(FRAME_LEN), .EOF_MARGIN(EOF_MARGIN)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof_seen(sof_seen),
    .frame_cnt(frame_cnt), .eof_mark(eof_mark)
  );

  AST_NO_DISABLED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_en | ls_drv_en) & ~port_en) == '0); // R3
  AST_UP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    up_drv_en |-> (drv_en == '0 && ls_drv_en == '0)); // R7
  AST_SLOW_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_drv_en & ~drv_en) == '0); // R4
endmodule

// File: tb/sim_hub_fwd_gate.sv
`timescale 1ns/1ps
module sim_hub_fwd_gate;
  localparam int NP = 4;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bit_en, pkt_start, pre_done, pkt_end, sof_seen;
  logic [NP-1:0] port_en, port_ls, dn_rx;
  logic [NP-1:0] drv_en, ls_drv_en;
  logic up_drv_en, eof_mark;
  logic [13:0] frame_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  hub_fwd_gate u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .port_en(port_en), .port_ls(port_ls),
    .dn_rx(dn_rx), .pkt_start(pkt_start), .pre_done(pre_done), .pkt_end(pkt_end),
    .sof_seen(sof_seen), .drv_en(drv_en), .ls_drv_en(ls_drv_en), .up_drv_en(up_drv_en),
    .frame_cnt(frame_cnt), .eof_mark(eof_mark)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_dn(input string req, input logic [NP-1:0] ed, input logic [NP-1:0] el);
    chk(req, "drv_en", int'(drv_en), int'(ed));
    chk(req, "ls_drv_en", int'(ls_drv_en), int'(el));
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; pkt_start = 1'b0; pre_done = 1'b0;
    pkt_end = 1'b0; sof_seen = 1'b0; port_en = '0; port_ls = '0; dn_rx = '0;
    repeat (3) cyc();
    chk_dn("R1", '0, '0);
    chk("R1", "up_drv_en", int'(up_drv_en), 0);
    chk("R1", "frame_cnt", int'(frame_cnt), 0);
    chk("R1", "eof_mark", int'(eof_mark), 0);
    rst_n = 1'b1;
    cyc();
    chk_dn("R1", '0, '0);
    chk("R1", "frame_cnt", int'(frame_cnt), 0);

    // Sweep all enable/speed combinations through a preamble packet
    for (int e = 0; e < 16; e++) begin
      for (int l = 0; l < 16; l++) begin
        logic [NP-1:0] en, ls;
        en = NP'(e); ls = NP'(l);
        port_en = en; port_ls = ls;
        pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
        chk_dn("R2", en & ~ls, '0);
        pre_done = 1'b1; cyc(); pre_done = 1'b0;
        chk_dn("R4", en & ~ls, '0);
        for (int k = 1; k <= 4; k++) begin
          bit_en = 1'b1; cyc(); bit_en = 1'b0;
          if (k < 4) chk_dn("R5", en & ~ls, '0);
          else       chk_dn("R4", en, en & ls);
          cyc();
          if (k < 4) chk_dn("R5", en & ~ls, '0);
        end
        pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
        chk_dn("R11", en, en & ls);
        pkt_end = 1'b1; cyc(); pkt_end = 1'b0;
        chk_dn("R6", '0, '0);
        chk("R6", "up_drv_en", int'(up_drv_en), 0);
      end
    end

    // Live masking during a low-speed phase
    port_en = 4'hF; port_ls = 4'b0110;
    pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
    pre_done = 1'b1; cyc(); pre_done = 1'b0;
    bit_en = 1'b1; repeat (4) cyc(); bit_en = 1'b0;
    chk_dn("R4", 4'hF, 4'b0110);
    port_en = 4'b1010; #1;
    chk_dn("R3", 4'b1010, 4'b0010);
    port_ls = 4'b0000; #1;
    chk_dn("R3", 4'b1010, 4'b0000);
    cyc();
    pkt_end = 1'b1; cyc(); pkt_end = 1'b0;
    chk_dn("R6", '0, '0);

    // End of packet before the wait finishes
    port_en = 4'hF; port_ls = 4'b1001;
    pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
    pre_done = 1'b1; cyc(); pre_done = 1'b0;
    bit_en = 1'b1; cyc(); bit_en = 1'b0;
    pkt_end = 1'b1; cyc(); pkt_end = 1'b0;
    chk_dn("R6", '0, '0);
    bit_en = 1'b1; repeat (4) cyc(); bit_en = 1'b0;
    chk_dn("R6", '0, '0);

    // Upstream sweep
    port_ls = 4'b0101;
    for (int e = 0; e < 16; e++) begin
      for (int d = 0; d < 16; d++) begin
        port_en = NP'(e); dn_rx = NP'(d);
        cyc();
        chk("R7", "up_drv_en", int'(up_drv_en), ((e & d) != 0) ? 1 : 0);
        chk_dn("R7", '0, '0);
        dn_rx = '0;
        cyc();
        chk("R7", "up_drv_en", int'(up_drv_en), 0);
      end
    end

    // pkt_start wins over upstream activity
    port_en = 4'hF; dn_rx = 4'h1; pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
    chk("R7", "up_drv_en", int'(up_drv_en), 0);
    chk_dn("R7", 4'b1010, '0);
    dn_rx = '0;
    pkt_end = 1'b1; cyc(); pkt_end = 1'b0;

    // pre_done while idle is ignored; the next packet stays full speed
    pre_done = 1'b1; cyc(); pre_done = 1'b0;
    bit_en = 1'b1; repeat (5) cyc(); bit_en = 1'b0;
    chk_dn("R11", '0, '0);
    pkt_start = 1'b1; cyc(); pkt_start = 1'b0;
    bit_en = 1'b1; repeat (5) cyc(); bit_en = 1'b0;
    chk_dn("R11", 4'b1010, '0);
    pkt_end = 1'b1; cyc(); pkt_end = 1'b0;

    // Frame timer
    sof_seen = 1'b1; cyc(); sof_seen = 1'b0;
    chk("R8", "frame_cnt", int'(frame_cnt), 0);
    bit_en = 1'b1;
    repeat (11967) cyc();
    chk("R9", "frame_cnt", int'(frame_cnt), 11967);
    chk("R10", "eof_mark", int'(eof_mark), 0);
    cyc();
    chk("R10", "frame_cnt", int'(frame_cnt), 11968);
    chk("R10", "eof_mark", int'(eof_mark), 1);
    repeat (31) cyc();
    chk("R9", "frame_cnt", int'(frame_cnt), 11999);
    chk("R10", "eof_mark", int'(eof_mark), 1);
    cyc();
    chk("R9", "frame_cnt", int'(frame_cnt), 0);
    chk("R10", "eof_mark", int'(eof_mark), 0);
    repeat (5) cyc();
    chk("R9", "frame_cnt", int'(frame_cnt), 5);
    bit_en = 1'b0; repeat (3) cyc();
    chk("R9", "frame_cnt", int'(frame_cnt), 5);
    bit_en = 1'b1; sof_seen = 1'b1; cyc(); sof_seen = 1'b0;
    chk("R8", "frame_cnt", int'(frame_cnt), 0);
    cyc();
    chk("R8", "frame_cnt", int'(frame_cnt), 1);
    bit_en = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule